// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block follows the address phase of each I2C transfer and decides whether the local slave answers. Four programmable slots each hold an address, a 7-bit/10-bit mode bit and a general-call enable. The block sees the bus as a serial bit view: one pulse per sampled bit (SDA taken on the rising edge of SCL), plus single-cycle START (also used for repeated START) and STOP indications from a bus front end. It returns an acknowledge request for the SDA driver, along with the winning slot index, a general-call flag and the transfer direction.

The bit input is valid-only. An I2C master cannot be stalled at the bit level here, so there is no ready signal and no back-pressure. Every `bit_vld` pulse is consumed in the cycle it appears. The slot write port and all outputs are plain level signals. The matcher takes part only while `slave_en` is high. When it is low, the slots are kept but have no effect.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset every slot holds mode 0, general-call enable 0 and address 0. `ack_req`, `addr_hit`, `match_idx`, `gen_call` and `rw_dir` are all 0.
- R2: A slot whose whole value (mode, general-call enable, address) is zero never causes an acknowledge.
- R3: In 7-bit mode (mode bit 0), bits [7:1] of an address byte that is not 0x00 and does not begin with 11110 are compared with slot address bits [7:1]. Slot bit 0 is ignored. `rw_dir` takes byte bit 0 (1 = read).
- R4: In 10-bit mode (mode bit 1), the first byte 11110 a9 a8 rw is acknowledged when a 10-bit slot has address[9:8] = a9 a8. The second byte must equal address[7:0]. Only then are the acknowledge and `addr_hit` given. `rw_dir` comes from bit 0 of the first byte.
- R5: Address byte 0x00 is acknowledged by a slot with its general-call enable set, and `gen_call` is raised with `rw_dir` = 0. Byte 0x01 is never acknowledged.
- R6: When several slots match, the lowest-numbered slot wins and its index appears on `match_idx`.
- R7: START restarts the address phase, including in the middle of a byte. START and STOP both clear `ack_req` and `addr_hit` on the next cycle.
- R8: While `slave_en` is 0, nothing is acknowledged and `addr_hit` stays 0.
- R9: `ack_req` rises in the cycle after the eighth `bit_vld` of an address byte. It falls in the cycle after the following (ninth) `bit_vld`.
- R10: A 7-bit slot never matches a byte whose top five bits are 11110, even if its stored address bits [7:1] equal that byte.
- R11: After a final match, later bits do not change `addr_hit`, `match_idx`, `gen_call` or `rw_dir`, and they raise no further `ack_req`, until START or STOP.
- R12: A cycle with `cfg_we` high writes {`cfg_mode`, `cfg_gc_en`, `cfg_addr`} into slot `cfg_sel`. The new value is used for the next address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_en | input | 1 | Slave participation enable |
| bit_vld | input | 1 | One-cycle pulse per sampled SDA bit |
| bit_val | input | 1 | SDA value for the current `bit_vld` |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| cfg_we | input | 1 | Slot write strobe |
| cfg_sel | input | 2 | Slot number to write |
| cfg_mode | input | 1 | 0 = 7-bit, 1 = 10-bit |
| cfg_gc_en | input | 1 | General-call enable |
| cfg_addr | input | 10 | Slot address value |
| ack_req | output | 1 | Drive SDA low during the acknowledge clock |
| addr_hit | output | 1 | Address phase ended in a match |
| match_idx | output | 2 | Winning slot, valid with `addr_hit` |
| gen_call | output | 1 | Match was a general call |
| rw_dir | output | 1 | Transfer direction, 1 = read |

## Verification
A wrong internal phase shows up at the ports within one bus bit. The acknowledge appears or goes missing in the cycle after the eighth or ninth `bit_vld`, and the cycle-accurate model flags it there. A lost 10-bit candidate mask only shows on the second byte, so 10-bit tests use both a matching and a mismatching low byte. Corrupt priority or hold state becomes visible as a changed `match_idx` or `rw_dir` during the data bits that follow a hit.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef struct packed {
    logic              ten_bit;
    logic              gc_en;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ACK1, ST_ADR2, ST_ACKF, ST_HOLD, ST_SKIP
  } mst_t;
endpackage

// File: rtl/i2c_am_slots.sv
module i2c_am_slots
  import i2c_am_pkg::*;
#(
  parameter int NSLOTS = 4,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] sel,
  input  slot_t            wdata,
  output slot_t            slots [NSLOTS]
);
  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    slot_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (we && (sel == IDX_W'(g))) slot_q <= wdata;
    end
    assign slots[g] = slot_q;
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  slot_t             slot,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              gc_hit,
  output logic              hit7,
  output logic              hi10,
  output logic              lo10
);
  logic live, ten_hdr, zero7;

  assign live    = |slot;
  assign ten_hdr = (rx_byte[7:3] == TEN_PREFIX);
  assign zero7   = (rx_byte[7:1] == 7'd0);

  assign gc_hit = live && slot.gc_en && (rx_byte == '0);
  assign hit7   = live && !slot.ten_bit && !zero7 && !ten_hdr &&
                  (slot.addr[7:1] == rx_byte[7:1]);
  assign hi10   = live && slot.ten_bit && ten_hdr &&
                  (slot.addr[9:8] == rx_byte[2:1]);
  assign lo10   = live && slot.ten_bit && (slot.addr[7:0] == rx_byte);
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int NSLOTS = 4,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic [NSLOTS-1:0] vec,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int NSLOTS = 4,
  localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic              cfg_mode,
  input  logic              cfg_gc_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              ack_req,
  output logic              addr_hit,
  output logic [IDX_W-1:0]  match_idx,
  output logic              gen_call,
  output logic              rw_dir
);
  slot_t slots [NSLOTS];
  slot_t wdata;

  mst_t              st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic [NSLOTS-1:0] pend_q;
  logic              rw_pend_q;

  logic [BYTE_W-1:0] byte_now;
  logic              last_bit, is_gc, is_ten;
  logic [NSLOTS-1:0] gc_vec, hit7_vec, hi10_vec, lo10_vec;
  logic [NSLOTS-1:0] pick_vec;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;

  assign wdata = '{ten_bit: cfg_mode, gc_en: cfg_gc_en, addr: cfg_addr};

  i2c_am_slots #(.NSLOTS(NSLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(wdata), .slots(slots)
  );

  assign byte_now = {sh_q, bit_val};
  assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));
  assign is_gc    = (byte_now == '0);
  assign is_ten   = (byte_now[7:3] == TEN_PREFIX);

  for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
    i2c_am_cmp u_cmp (
      .slot(slots[g]), .rx_byte(byte_now),
      .gc_hit(gc_vec[g]), .hit7(hit7_vec[g]),
      .hi10(hi10_vec[g]), .lo10(lo10_vec[g])
    );
  end

  always_comb begin
    if (st_q == ST_ADR2) pick_vec = pend_q & lo10_vec;
    else if (is_gc)      pick_vec = gc_vec;
    else if (is_ten)     pick_vec = hi10_vec;
    else                 pick_vec = hit7_vec;
  end

  i2c_am_prio #(.NSLOTS(NSLOTS)) u_prio (
    .vec(pick_vec), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      pend_q    <= '0;
      rw_pend_q <= 1'b0;
      ack_req   <= 1'b0;
      addr_hit  <= 1'b0;
      match_idx <= '0;
      gen_call  <= 1'b0;
      rw_dir    <= 1'b0;
    end else if (!slave_en || start_det || stop_det) begin
      st_q      <= (slave_en && start_det) ? ST_ADR1 : ST_IDLE;
      cnt_q     <= '0;
      pend_q    <= '0;
      ack_req   <= 1'b0;
      addr_hit  <= 1'b0;
      match_idx <= '0;
      gen_call  <= 1'b0;
      rw_dir    <= 1'b0;
    end else if (bit_vld) begin
      unique case (st_q)
        ST_ADR1, ST_ADR2: begin
          sh_q  <= byte_now[BYTE_W-2:0];
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            if (!pick_any) begin
              st_q <= ST_SKIP;
            end else if (st_q == ST_ADR1 && is_ten) begin
              st_q      <= ST_ACK1;
              pend_q    <= hi10_vec;
              rw_pend_q <= byte_now[0];
              ack_req   <= 1'b1;
            end else begin
              st_q      <= ST_ACKF;
              ack_req   <= 1'b1;
              addr_hit  <= 1'b1;
              match_idx <= pick_idx;
              gen_call  <= (st_q == ST_ADR1) && is_gc;
              rw_dir    <= (st_q == ST_ADR1) ? byte_now[0] : rw_pend_q;
            end
          end
        end
        ST_ACK1: begin
          ack_req <= 1'b0;
          cnt_q   <= '0;
          st_q    <= ST_ADR2;
        end
        ST_ACKF: begin
          ack_req <= 1'b0;
          st_q    <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slave_en,
  input logic             bit_vld,
  input logic             start_det,
  input logic             stop_det,
  input logic             ack_req,
  input logic             addr_hit,
  input logic [IDX_W-1:0] match_idx,
  input logic             gen_call,
  input logic             rw_dir
);
  // R8
  slave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |=> (!ack_req && !addr_hit));

  // R7
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!ack_req && !addr_hit));

  // R9
  ack_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && bit_vld) |=> !ack_req);

  // R9
  ack_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(bit_vld));

  // R9
  hit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> ack_req);

  // R11
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hit && slave_en && !start_det && !stop_det) |=>
      (addr_hit && $stable(match_idx) && $stable(rw_dir) && $stable(gen_call)));

  // R5
  gc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> (addr_hit && !rw_dir));
endmodule

bind i2c_addr_matcher i2c_am_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .bit_vld(bit_vld),
  .start_det(start_det), .stop_det(stop_det), .ack_req(ack_req),
  .addr_hit(addr_hit), .match_idx(match_idx), .gen_call(gen_call),
  .rw_dir(rw_dir)
);

// File: tb/sim_i2c_addr_matcher.sv
`timescale 1ns/1ps
module sim_i2c_addr_matcher;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slave_en = 1'b1, bit_vld = 1'b0, bit_val = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0;
  logic cfg_we = 1'b0, cfg_mode = 1'b0, cfg_gc_en = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [9:0] cfg_addr = '0;
  logic ack_req, addr_hit, gen_call, rw_dir;
  logic [1:0] match_idx;

  always #10 clk = ~clk;

  i2c_addr_matcher u0 (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .bit_vld(bit_vld),
    .bit_val(bit_val), .start_det(start_det), .stop_det(stop_det),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
    .cfg_gc_en(cfg_gc_en), .cfg_addr(cfg_addr), .ack_req(ack_req),
    .addr_hit(addr_hit), .match_idx(match_idx), .gen_call(gen_call),
    .rw_dir(rw_dir)
  );

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference: phase 0 idle,1 first byte,2 first ack,3 second byte,4 final ack,5 hold,6 skip
  logic       m_mode [4];
  logic       m_gc   [4];
  logic [9:0] m_addr [4];
  int   m_ph = 0, m_cnt = 0, m_win;
  logic [7:0] m_sh = 0;
  bit   m_mask [4];
  logic m_rwp = 0;
  logic e_ack = 0, e_hit = 0, e_gc = 0, e_rw = 0;
  logic [1:0] e_idx = 0;

  function automatic bit live(int i);
    return (m_mode[i] || m_gc[i] || m_addr[i] != 0);
  endfunction

  function automatic int first_win(logic [7:0] b);
    for (int i = 0; i < 4; i++) begin
      if (b == 8'h00) begin
        if (m_gc[i]) return i;
      end else if (b[7:3] == 5'b11110) begin
        if (live(i) && m_mode[i] && m_addr[i][9:8] == b[2:1]) return i;
      end else if (live(i) && !m_mode[i] && b[7:1] != 0 && m_addr[i][7:1] == b[7:1]) return i;
    end
    return -1;
  endfunction

  task automatic m_clear();
    e_ack = 0; e_hit = 0; e_idx = 0; e_gc = 0; e_rw = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_gc[i] = 0; m_addr[i] = 0; m_mask[i] = 0; end
      m_ph = 0; m_cnt = 0; m_clear();
    end else begin
      if (!slave_en || stop_det) begin m_ph = 0; m_clear(); end
      else if (start_det) begin m_ph = 1; m_cnt = 0; m_clear(); end
      else if (bit_vld) begin
        if (m_ph == 1 || m_ph == 3) begin
          m_sh = {m_sh[6:0], bit_val};
          m_cnt++;
          if (m_cnt == 8) begin
            m_win = -1;
            if (m_ph == 3) begin
              for (int i = 3; i >= 0; i--)
                if (m_mask[i] && live(i) && m_mode[i] && m_addr[i][7:0] == m_sh) m_win = i;
            end else m_win = first_win(m_sh);
            if (m_win < 0) m_ph = 6;
            else if (m_ph == 1 && m_sh[7:3] == 5'b11110) begin
              for (int i = 0; i < 4; i++)
                m_mask[i] = live(i) && m_mode[i] && m_addr[i][9:8] == m_sh[2:1];
              m_rwp = m_sh[0]; e_ack = 1; m_ph = 2;
            end else begin
              e_ack = 1; e_hit = 1; e_idx = 2'(m_win);
              e_gc = (m_ph == 1) && (m_sh == 0);
              e_rw = (m_ph == 1) ? m_sh[0] : m_rwp;
              m_ph = 4;
            end
          end
        end else if (m_ph == 2) begin e_ack = 0; m_ph = 3; m_cnt = 0; end
        else if (m_ph == 4) begin e_ack = 0; m_ph = 5; end
      end
      if (cfg_we) begin
        m_mode[cfg_sel] = cfg_mode; m_gc[cfg_sel] = cfg_gc_en; m_addr[cfg_sel] = cfg_addr;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk({cur_req, " model ack_req"},   {7'd0, ack_req},   {7'd0, e_ack});
      chk({cur_req, " model addr_hit"},  {7'd0, addr_hit},  {7'd0, e_hit});
      chk({cur_req, " model match_idx"}, {6'd0, match_idx}, {6'd0, e_idx});
      chk({cur_req, " model gen_call"},  {7'd0, gen_call},  {7'd0, e_gc});
      chk({cur_req, " model rw_dir"},    {7'd0, rw_dir},    {7'd0, e_rw});
    end
  endtask

  task automatic send_bit(logic b);
    bit_vld = 1; bit_val = b; tick();
    bit_vld = 0; tick(); tick();
  endtask

  task automatic send_byte(logic [7:0] b, output logic a, output logic h);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    a = ack_req; h = addr_hit;
    send_bit(1'b0);
  endtask

  task automatic bus_start(); start_det = 1; tick(); start_det = 0; tick(); endtask
  task automatic bus_stop();  stop_det = 1;  tick(); stop_det = 0;  tick(); endtask

  task automatic wr_slot(logic [1:0] s, logic md, logic gc, logic [9:0] ad);
    cfg_we = 1; cfg_sel = s; cfg_mode = md; cfg_gc_en = gc; cfg_addr = ad;
    tick(); cfg_we = 0; tick();
  endtask

  logic a, h;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 ack_req", {7'd0, ack_req}, 8'd0);
    chk("R1 addr_hit", {7'd0, addr_hit}, 8'd0);
    chk("R1 match_idx", {6'd0, match_idx}, 8'd0);
    // R2 all slots zero: no acknowledge
    cur_req = "R2";
    bus_start(); send_byte(8'hA0, a, h); chk("R2 zero slots 0xA0", {7'd0, a}, 8'd0);
    bus_start(); send_byte(8'h00, a, h); chk("R2 zero slots 0x00", {7'd0, a}, 8'd0);
    bus_stop();
    // R12 program slots
    cur_req = "R12";
    wr_slot(2'd0, 1'b0, 1'b0, 10'h0A1);
    wr_slot(2'd1, 1'b1, 1'b0, 10'h2C5);
    wr_slot(2'd2, 1'b0, 1'b1, 10'h0A0);
    // R3 R6 7-bit write, slots 0 and 2 both match, bit0 of slot0 ignored
    cur_req = "R3";
    bus_start(); send_byte(8'hA0, a, h);
    chk("R3 7-bit ack", {7'd0, a}, 8'd1);
    chk("R6 lowest slot wins", {6'd0, match_idx}, 8'd0);
    chk("R3 rw write", {7'd0, rw_dir}, 8'd0);
    // R11 data bits ignored
    cur_req = "R11";
    send_byte(8'hA1, a, h);
    chk("R11 no ack on data", {7'd0, a}, 8'd0);
    chk("R11 hit held", {7'd0, addr_hit}, 8'd1);
    cur_req = "R7";
    bus_stop();
    chk("R7 stop clears hit", {7'd0, addr_hit}, 8'd0);
    // R3 read direction
    cur_req = "R3";
    bus_start(); send_byte(8'hA1, a, h);
    chk("R3 read ack", {7'd0, a}, 8'd1);
    chk("R3 rw read", {7'd0, rw_dir}, 8'd1);
    // R5 general call via slot 2, then R7 repeated start to 0x01
    cur_req = "R5";
    bus_start(); send_byte(8'h00, a, h);
    chk("R5 gc ack", {7'd0, a}, 8'd1);
    chk("R5 gc flag", {7'd0, gen_call}, 8'd1);
    chk("R5 gc slot", {6'd0, match_idx}, 8'd2);
    bus_start();
    chk("R7 restart clears hit", {7'd0, addr_hit}, 8'd0);
    send_byte(8'h01, a, h);
    chk("R5 0x01 no ack", {7'd0, a}, 8'd0);
    bus_stop();
    // R4 10-bit write and read to 0x2C5
    cur_req = "R4";
    bus_start(); send_byte(8'hF4, a, h);
    chk("R4 first byte ack", {7'd0, a}, 8'd1);
    chk("R4 first byte no hit", {7'd0, h}, 8'd0);
    send_byte(8'hC5, a, h);
    chk("R4 second byte ack", {7'd0, a}, 8'd1);
    chk("R4 slot 1", {6'd0, match_idx}, 8'd1);
    bus_start(); send_byte(8'hF5, a, h); send_byte(8'hC5, a, h);
    chk("R4 10-bit read dir", {7'd0, rw_dir}, 8'd1);
    bus_start(); send_byte(8'hF4, a, h); send_byte(8'hC4, a, h);
    chk("R4 low byte mismatch", {7'd0, a}, 8'd0);
    bus_start(); send_byte(8'hF2, a, h);
    chk("R4 high bits mismatch", {7'd0, a}, 8'd0);
    bus_stop();
    // R7 START in the middle of a byte
    cur_req = "R7";
    bus_start(); send_bit(1); send_bit(0); send_bit(1);
    bus_start(); send_byte(8'hA0, a, h);
    chk("R7 mid-byte restart", {7'd0, a}, 8'd1);
    bus_stop();
    // R10 7-bit slot in reserved range
    cur_req = "R10";
    wr_slot(2'd3, 1'b0, 1'b0, 10'h0F6);
    bus_start(); send_byte(8'hF6, a, h);
    chk("R10 reserved prefix", {7'd0, a}, 8'd0);
    bus_stop();
    wr_slot(2'd3, 1'b0, 1'b0, 10'h000);
    // R8 slave disabled
    cur_req = "R8";
    slave_en = 0; tick();
    bus_start(); send_byte(8'hA0, a, h);
    chk("R8 disabled no ack", {7'd0, a}, 8'd0);
    chk("R8 disabled no hit", {7'd0, h}, 8'd0);
    slave_en = 1; tick();
    // R9 timing once more under model compare
    cur_req = "R9";
    bus_start(); send_byte(8'hA0, a, h);
    chk("R9 ack after eighth bit", {7'd0, a}, 8'd1);
    chk("R9 ack dropped after ninth", {7'd0, ack_req}, 8'd0);
    bus_stop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule